// File: doc/BRIEF.md
# UART FIFO Trigger Level Controller

This block produces the receive and transmit FIFO trigger flags for a two-channel UART whose FIFOs hold 64 bytes each. The flags feed the interrupt and DMA request logic. Each channel holds an 8-bit trigger-level register and also receives a legacy 2-bit threshold code for each direction from the FIFO control register. The receive flag compares the characters waiting in the receive FIFO against its threshold. The transmit flag compares the free spaces in the transmit FIFO against its threshold. The FIFOs themselves, the serial engines, flow control and bus decoding sit outside this block. FIFO counts arrive as plain inputs.

The block also serves a read-only status byte that gathers the DMA-related flags of both channels. That byte appears only when the read conditions hold. In every other case the read path returns the ordinary scratch data supplied from outside. All pins are plain control and status signals, sampled each clock. No stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `fifo_trig_ctrl`

## Requirements
- R1: A write to a channel's trigger-level register takes effect only when both that channel's enhanced-mode bit (`enh_mode`) and its register-access bit (`tl_access`) are 1. Otherwise the register keeps its value.
- R2: The receive threshold is 4 times bits 7:4 of the trigger-level register. The transmit threshold is 4 times bits 3:0.
- R3: The receive flag compares the receive fill count and the transmit flag compares the transmit free-space count, each using count >= threshold.
- R4: When a nibble is zero, that direction takes the legacy code instead. Receive code (`fcr_rx_code`) values 0,1,2,3 give 8,16,56,60. Transmit code (`fcr_tx_code`) values 0,1,2,3 give 8,16,32,56. A non-zero nibble makes the block ignore the code.
- R5: The receive and transmit directions each choose between nibble and legacy code on their own.
- R6: Each flag is registered. It shows the comparison result one clock after the inputs that produced it, so it rises and falls one cycle after the count crosses the threshold.
- R7: A read at address 3'b111 with `chan_sel`=1, `rdy_en`=1 and `loopback`=0 returns the status byte. Bit 0 is the channel A transmit flag, bit 1 the channel B transmit flag, bit 4 the channel A receive flag and bit 5 the channel B receive flag. Bits 7:6 and 3:2 read 0.
- R8: Any other read, including address 3'b111 when a status condition fails, returns `scratch_data` unchanged.
- R9: Every 8-bit value written under the gate is stored as written, with no ordering check between the nibbles, and that value alone sets the thresholds.
- R10: Reset clears both trigger-level registers to zero, so legacy codes apply. Reset also drops all flags.
- R11: A write affects only the channel named by `wr_chan`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for a trigger-level register |
| wr_chan | input | 1 | Target channel of the write (0 = A, 1 = B) |
| wr_data | input | 8 | Value to write |
| enh_mode | input | 2 | Per-channel enhanced-mode enable |
| tl_access | input | 2 | Per-channel trigger-register access enable |
| fcr_rx_code | input | 4 | Legacy receive codes, 2 bits per channel |
| fcr_tx_code | input | 4 | Legacy transmit codes, 2 bits per channel |
| rx_fill | input | 14 | Receive FIFO characters available, 7 bits per channel |
| tx_free | input | 14 | Transmit FIFO free spaces, 7 bits per channel |
| rx_trig | output | 2 | Per-channel receive trigger flag |
| tx_trig | output | 2 | Per-channel transmit trigger flag |
| rd_addr | input | 3 | Register read address |
| chan_sel | input | 1 | A channel is selected for access |
| rdy_en | input | 1 | Status byte read enable |
| loopback | input | 1 | Loopback mode active |
| scratch_data | input | 8 | Data of the ordinary register path |
| rd_data | output | 8 | Read data |

## Verification
The bench drives fill and free counts that land exactly on each threshold, one below it and one above it. A design with an off-by-one comparison or a wrong multiplier would then raise a flag a step early or late. It writes with only one of the two gate bits set, and it writes values whose upper nibble exceeds the lower. A loose gate would change thresholds without permission, and a "correcting" design would alter them. It also mixes a zero nibble in one direction with a non-zero nibble in the other. A design that falls back as a whole byte would pick the wrong source there. Reads at address 3'b111 toggle each status condition one at a time, so a mux that skips a condition would leak the status byte in place of the scratch data.

// File: rtl/fifo_trig_pkg.sv
package fifo_trig_pkg;
  localparam int FIFO_DEPTH = 64;
  localparam int CNT_W      = $clog2(FIFO_DEPTH + 1);
  localparam int STEP       = 4;

  function automatic logic [CNT_W-1:0] legacy_rx(input logic [1:0] code);
    case (code)
      2'd0:    legacy_rx = CNT_W'(8);
      2'd1:    legacy_rx = CNT_W'(16);
      2'd2:    legacy_rx = CNT_W'(56);
      default: legacy_rx = CNT_W'(60);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] legacy_tx(input logic [1:0] code);
    case (code)
      2'd0:    legacy_tx = CNT_W'(8);
      2'd1:    legacy_tx = CNT_W'(16);
      2'd2:    legacy_tx = CNT_W'(32);
      default: legacy_tx = CNT_W'(56);
    endcase
  endfunction
endpackage

// File: rtl/trig_lvl_chan.sv
module trig_lvl_chan
  import fifo_trig_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [7:0]       wr_data,
  input  logic [1:0]       rx_code,
  input  logic [1:0]       tx_code,
  input  logic [CNT_W-1:0] rx_cnt,
  input  logic [CNT_W-1:0] tx_cnt,
  output logic             rx_flag,
  output logic             tx_flag
);
  logic [7:0]       lvl_q;
  logic [CNT_W-1:0] rx_thr, tx_thr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lvl_q <= '0;
    else if (wr_stb) lvl_q <= wr_data;
  end

  always_comb begin
    rx_thr = (lvl_q[7:4] != 4'd0) ? CNT_W'(lvl_q[7:4]) * CNT_W'(STEP) : legacy_rx(rx_code);
    tx_thr = (lvl_q[3:0] != 4'd0) ? CNT_W'(lvl_q[3:0]) * CNT_W'(STEP) : legacy_tx(tx_code);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_flag <= 1'b0;
      tx_flag <= 1'b0;
    end else begin
      rx_flag <= (rx_cnt >= rx_thr);
      tx_flag <= (tx_cnt >= tx_thr);
    end
  end

  // R1
  no_gated_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(lvl_q));
  // R9
  write_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> lvl_q == $past(wr_data));
  // R6
  rx_flag_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt < CNT_W'(STEP)) |=> !rx_flag);
  // R6
  tx_flag_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt < CNT_W'(STEP)) |=> !tx_flag);
  // R2
  rx_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt == CNT_W'(FIFO_DEPTH)) |=> rx_flag);
endmodule

// File: rtl/ready_rd_mux.sv
module ready_rd_mux #(
  parameter int NCH = 2
) (
  input  logic [2:0]     rd_addr,
  input  logic           chan_sel,
  input  logic           rdy_en,
  input  logic           loopback,
  input  logic [7:0]     scratch_data,
  input  logic [NCH-1:0] rx_flag,
  input  logic [NCH-1:0] tx_flag,
  output logic [7:0]     rd_data
);
  localparam logic [2:0] STAT_ADDR = 3'b111;
  localparam int         RX_BASE   = 4;
  logic [7:0] stat;
  logic       show;

  always_comb begin
    stat = '0;
    for (int c = 0; c < NCH; c++) begin
      stat[c]           = tx_flag[c];
      stat[RX_BASE + c] = rx_flag[c];
    end
    show    = (rd_addr == STAT_ADDR) && chan_sel && rdy_en && !loopback;
    rd_data = show ? stat : scratch_data;
  end
endmodule

// File: rtl/fifo_trig_ctrl.sv
module fifo_trig_ctrl
  import fifo_trig_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               wr_chan,
  input  logic [7:0]         wr_data,
  input  logic [NCH-1:0]     enh_mode,
  input  logic [NCH-1:0]     tl_access,
  input  logic [2*NCH-1:0]   fcr_rx_code,
  input  logic [2*NCH-1:0]   fcr_tx_code,
  input  logic [NCH*CNT_W-1:0] rx_fill,
  input  logic [NCH*CNT_W-1:0] tx_free,
  output logic [NCH-1:0]     rx_trig,
  output logic [NCH-1:0]     tx_trig,
  input  logic [2:0]         rd_addr,
  input  logic               chan_sel,
  input  logic               rdy_en,
  input  logic               loopback,
  input  logic [7:0]         scratch_data,
  output logic [7:0]         rd_data
);
  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic stb;
    assign stb = wr_en && (int'(wr_chan) == c) && enh_mode[c] && tl_access[c];
    trig_lvl_chan u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_stb  (stb),
      .wr_data (wr_data),
      .rx_code (fcr_rx_code[2*c +: 2]),
      .tx_code (fcr_tx_code[2*c +: 2]),
      .rx_cnt  (rx_fill[c*CNT_W +: CNT_W]),
      .tx_cnt  (tx_free[c*CNT_W +: CNT_W]),
      .rx_flag (rx_trig[c]),
      .tx_flag (tx_trig[c])
    );
  end

  ready_rd_mux #(.NCH(NCH)) u_mux (
    .rd_addr      (rd_addr),
    .chan_sel     (chan_sel),
    .rdy_en       (rdy_en),
    .loopback     (loopback),
    .scratch_data (scratch_data),
    .rx_flag      (rx_trig),
    .tx_flag      (tx_trig),
    .rd_data      (rd_data)
  );

  // R7
  stat_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 3'b111 && chan_sel && rdy_en && !loopback) |->
      (rd_data[7:6] == 2'b00 && rd_data[3:2] == 2'b00));
  // R8
  scratch_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loopback || !rdy_en || !chan_sel) |-> rd_data == scratch_data);
  // R10
  reset_flags_chk: assert property (@(posedge clk)
    !rst_n |-> (rx_trig == '0 && tx_trig == '0));
endmodule

// File: tb/fifo_trig_ctrl_tb.sv
module fifo_trig_ctrl_tb_top;
  logic        clk = 0, rst_n = 0;
  logic        wr_en = 0, wr_chan = 0;
  logic [7:0]  wr_data = 0;
  logic [1:0]  enh_mode = 0, tl_access = 0;
  logic [3:0]  fcr_rx_code = 0, fcr_tx_code = 0;
  logic [13:0] rx_fill = 0, tx_free = 0;
  logic [1:0]  rx_trig, tx_trig;
  logic [2:0]  rd_addr = 0;
  logic        chan_sel = 0, rdy_en = 0, loopback = 0;
  logic [7:0]  scratch_data = 0, rd_data;

  int checks = 0, errors = 0;
  int tl[2];
  bit m_rx[2], m_tx[2];

  always #10 clk = ~clk;

  fifo_trig_ctrl dut_i (.*);

  function automatic int rx_leg(int code);
    int t[4] = '{8, 16, 56, 60};
    return t[code];
  endfunction
  function automatic int tx_leg(int code);
    int t[4] = '{8, 16, 32, 56};
    return t[code];
  endfunction

  // reference model, updated on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin tl[c] = 0; m_rx[c] = 0; m_tx[c] = 0; end
    end else begin
      for (int c = 0; c < 2; c++) begin
        int rt, tt;
        rt = (tl[c] / 16 != 0) ? (tl[c] / 16) * 4 : rx_leg(int'(fcr_rx_code[2*c +: 2]));
        tt = (tl[c] % 16 != 0) ? (tl[c] % 16) * 4 : tx_leg(int'(fcr_tx_code[2*c +: 2]));
        m_rx[c] = int'(rx_fill[7*c +: 7]) >= rt;
        m_tx[c] = int'(tx_free[7*c +: 7]) >= tt;
      end
      if (wr_en && enh_mode[int'(wr_chan)] && tl_access[int'(wr_chan)])
        tl[int'(wr_chan)] = int'(wr_data);
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [7:0] exp_rd;
    for (int c = 0; c < 2; c++) begin
      chk("R2 R3 R4 R5 R6 R1 R9 R11 rx flag", int'(rx_trig[c]), int'(m_rx[c]));
      chk("R2 R3 R4 R5 R6 R1 R9 R11 tx flag", int'(tx_trig[c]), int'(m_tx[c]));
    end
    if (rd_addr == 3'b111 && chan_sel && rdy_en && !loopback)
      exp_rd = {2'b00, m_rx[1], m_rx[0], 2'b00, m_tx[1], m_tx[0]};
    else
      exp_rd = scratch_data;
    chk("R7 R8 read data", int'(rd_data), int'(exp_rd));
  endtask

  function automatic logic [6:0] near(int thr);
    int v;
    v = thr + int'($urandom_range(2)) - 1;
    if (v < 0) v = 0;
    if (v > 64) v = 64;
    return 7'(v);
  endfunction

  initial begin
    #400000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(7));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 rx flags", int'(rx_trig), 0);
    chk("R10 tx flags", int'(tx_trig), 0);
    rst_n = 1;
    // directed: legacy thresholds straight after reset (R10, R4)
    fcr_rx_code = 4'b1101; fcr_tx_code = 4'b0010;
    rx_fill = {7'd56, 7'd16}; tx_free = {7'd15, 7'd31};
    @(negedge clk); compare_all();
    rx_fill = {7'd55, 7'd15}; tx_free = {7'd16, 7'd32};
    @(negedge clk); compare_all();
    // R1: write with only one gate bit set, R9: upper nibble above lower
    wr_en = 1; wr_chan = 0; wr_data = 8'hF1; enh_mode = 2'b01; tl_access = 2'b00;
    @(negedge clk); compare_all();
    tl_access = 2'b01;
    @(negedge clk); compare_all();
    wr_en = 0;
    rx_fill = {7'd0, 7'd60}; tx_free = {7'd0, 7'd4};
    @(negedge clk); compare_all();
    rx_fill = {7'd0, 7'd59}; tx_free = {7'd0, 7'd3};
    @(negedge clk); compare_all();
    // R5 mixed: rx nibble zero, tx nibble set; R11 channel B only
    wr_en = 1; wr_chan = 1; wr_data = 8'h05; enh_mode = 2'b11; tl_access = 2'b10;
    @(negedge clk); compare_all();
    wr_en = 0; rx_fill = {7'd8, 7'd59}; tx_free = {7'd20, 7'd4};
    @(negedge clk); compare_all();
    // R7/R8 status read with each condition dropped in turn
    rd_addr = 3'b111; chan_sel = 1; rdy_en = 1; loopback = 0; scratch_data = 8'h5A;
    @(negedge clk); compare_all();
    loopback = 1; @(negedge clk); compare_all();
    loopback = 0; rdy_en = 0; @(negedge clk); compare_all();
    rdy_en = 1; chan_sel = 0; @(negedge clk); compare_all();
    chan_sel = 1; rd_addr = 3'b110; @(negedge clk); compare_all();
    // random phase with counts near the thresholds
    for (int i = 0; i < 4000; i++) begin
      wr_en       = ($urandom_range(3) == 0);
      wr_chan     = 1'($urandom_range(1));
      wr_data     = ($urandom_range(3) == 0) ? {4'($urandom_range(15)), 4'd0}
                                             : 8'($urandom_range(255));
      enh_mode    = 2'($urandom_range(3));
      tl_access   = 2'($urandom_range(3));
      fcr_rx_code = 4'($urandom_range(15));
      fcr_tx_code = 4'($urandom_range(15));
      for (int c = 0; c < 2; c++) begin
        int rt, tt;
        rt = (tl[c] / 16 != 0) ? (tl[c] / 16) * 4 : rx_leg(int'(fcr_rx_code[2*c +: 2]));
        tt = (tl[c] % 16 != 0) ? (tl[c] % 16) * 4 : tx_leg(int'(fcr_tx_code[2*c +: 2]));
        rx_fill[7*c +: 7] = ($urandom_range(3) == 0) ? 7'($urandom_range(64)) : near(rt);
        tx_free[7*c +: 7] = ($urandom_range(3) == 0) ? 7'($urandom_range(64)) : near(tt);
      end
      rd_addr      = ($urandom_range(1) == 0) ? 3'b111 : 3'($urandom_range(7));
      chan_sel     = ($urandom_range(3) != 0);
      rdy_en       = ($urandom_range(3) != 0);
      loopback     = ($urandom_range(3) == 0);
      scratch_data = 8'($urandom_range(255));
      @(negedge clk); compare_all();
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule